// File: doc/BRIEF.md
# Paged Descriptor Ring Index Manager

This block keeps the index and address bookkeeping for three circular descriptor rings that live in host memory: a request ring that the block consumes, and a completion ring and a message ring that the block produces into. Each ring is scattered over a small table of memory pages. For every pop or push the block returns the physical byte address of the descriptor slot to use. It also keeps the shared producer and consumer indices that software reads. The block never touches descriptor memory and never interprets descriptor contents.

Software first loads page frame numbers into a ring's page table and then issues a setup with the page count. From then on, the request ring is popped against a producer index that software supplies. Completions are pushed with no fullness check and are published in batches. Message posts are checked for room against a software consumer index and are published one at a time.

Top module: `dring_index_mgr`

## Requirements
- R1: `cfg_ring` selects the ring for configuration (0 request, 1 completion, 2 message, 3 none). A setup with page count P, where 1 <= P <= that ring's maximum, has four effects: the ring's log2 output becomes the bit length of (P*entries_per_page − 1), the index mask becomes 2^log2 − 1, the internal pointer and the published index are cleared to 0, and the ring's live bit is set.
- R2: A setup whose page count is 0 or greater than that ring's maximum page count changes nothing. A page-table write to an index at or beyond the ring's maximum is also ignored.
- R3: An accepted request pop returns the address (page_frame[page] << PAGE_SHIFT) + (m mod EPP) * DESC_B, where m = consumed & mask and page = m / EPP. The free-running consumed count then advances by one.
- R4: A request pop when `sw_req_prod` equals the consumed count returns `req_hit`=0 and `req_addr`=0, and it leaves the consumed count unchanged.
- R5: `req_cons_pub` changes only on `req_flush`, which loads the unmasked consumed count. Pops alone never change it.
- R6: Every push to a live completion ring is accepted, with no fullness check, and the ring wraps through the mask. `cmp_prod_pub` changes only on `cmp_flush`, which loads the unmasked filled count.
- R7: A message post is accepted when (filled − `sw_msg_cons`) mod 2^32 < mask + 1. An accepted post updates `msg_prod_pub` to the new unmasked filled count on the same edge that returns the address.
- R8: A message post to a full ring is dropped. A dropped post gives `msg_hit`=0 and `msg_addr`=0 and leaves `msg_prod_pub` unchanged.
- R9: A message ring setup is ignored unless the request ring is live.
- R10: A pop, push or post to a ring that is not live is refused, with hit 0 and address 0.
- R11: Reset or `clean` zeroes every pointer, mask, log2 value, published index, live bit and page-table entry. After a clean, a page that is not reloaded yields base address 0.
- R12: A result appears on the clock edge that samples the request. The hit outputs are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clean | input | 1 | Synchronous clear of all ring state and page tables |
| cfg_ring | input | 2 | Ring selected for configuration |
| cfg_ppn_we | input | 1 | Write one page frame number |
| cfg_page | input | PG_IW | Page-table index to write |
| cfg_ppn | input | PPN_W | Page frame number |
| cfg_init | input | 1 | Set up the selected ring |
| cfg_pages | input | PG_CW | Page count for setup |
| req_pop | input | 1 | Pop one request descriptor |
| sw_req_prod | input | 32 | Software request producer index |
| req_flush | input | 1 | Publish the request consumer index |
| req_addr | output | ADDR_W | Address of the popped request descriptor |
| req_hit | output | 1 | Pop returned a descriptor |
| cmp_push | input | 1 | Claim one completion slot |
| cmp_flush | input | 1 | Publish the completion producer index |
| cmp_addr | output | ADDR_W | Completion slot address |
| cmp_hit | output | 1 | Push accepted |
| msg_post | input | 1 | Claim one message slot |
| sw_msg_cons | input | 32 | Software message consumer index |
| msg_addr | output | ADDR_W | Message slot address |
| msg_hit | output | 1 | Post accepted |
| req_cons_pub | output | 32 | Published request consumer index |
| cmp_prod_pub | output | 32 | Published completion producer index |
| msg_prod_pub | output | 32 | Published message producer index |
| req_log2 | output | 6 | Request ring entry-count log2 |
| cmp_log2 | output | 6 | Completion ring entry-count log2 |
| msg_log2 | output | 6 | Message ring entry-count log2 |
| ring_live | output | 3 | Live bits: [0] request, [1] completion, [2] message |

## Verification
The bench builds the block with four entries per request page, eight per completion page and two per message page, 4 pages maximum for the data rings and 2 for the message ring. These small sizes let a three-page request ring reach its power-of-two mask (16 slots over 12 entries). The masked index then walks into a fourth page that was never loaded. Completions wrap many times in a few hundred cycles. A four-slot message ring fills after four posts, which makes full, partly drained and wrapped-subtraction cases (software consumer ahead of the producer) easy to drive.

// File: rtl/dring_pkg.sv
// Package: shared types and helpers for the descriptor ring index manager.
// Assumes 32-bit free-running ring indices.
package dring_pkg;

    localparam int IDX_W = 32;

    // Ring behaviour variant chosen per instance.
    typedef enum logic [1:0] {
        M_CONSUME = 2'd0,   // pops against a software producer index
        M_PRODUCE = 2'd1,   // pushes with no fullness check, batch publish
        M_ROOM    = 2'd2    // pushes with room check, immediate publish
    } mode_e;

    // Number of significant bits in v (0 for v == 0).
    function automatic logic [5:0] bit_len(input logic [IDX_W-1:0] v);
        logic [5:0] n;
        n = 6'd0;
        for (int i = 0; i < IDX_W; i++) begin
            if (v[i]) n = 6'(i + 1);
        end
        return n;
    endfunction

endpackage

// File: rtl/dring_pgtab.sv
// Module: per-ring page table holding page frame numbers.
// Assumes DEPTH is a power of two; the read port is combinational.
module dring_pgtab #(
    parameter int DEPTH = 4,
    parameter int PPN_W = 28,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clean,
    input  logic             we,
    input  logic [IW-1:0]    widx,
    input  logic [PPN_W-1:0] wppn,
    input  logic [IW-1:0]    ridx,
    output logic [PPN_W-1:0] rppn
);

    logic [PPN_W-1:0] tab [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Entry storage: cleared on reset/clean, loaded on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n || clean) begin
                tab[i] <= '0;
            end else if (we && widx == IW'(i)) begin
                tab[i] <= wppn;
            end
        end
    end

    // Lookup of the page selected by the ring's current index.
    assign rppn = tab[ridx];

endmodule

// File: rtl/dring_ring.sv
// Module: one descriptor ring: pointer, mask, published index, address.
// Assumes EPP and MAX_PG are powers of two >= 2 and EPP*DESC_B fits a page.
module dring_ring #(
    parameter dring_pkg::mode_e MODE = dring_pkg::M_CONSUME,
    parameter int ADDR_W     = 40,
    parameter int PAGE_SHIFT = 12,
    parameter int MAX_PG     = 4,
    parameter int EPP        = 32,
    parameter int DESC_B     = 128,
    parameter int WIDX_W     = 2,
    parameter int CNT_W      = 3,
    localparam int PPN_W     = ADDR_W - PAGE_SHIFT,
    localparam int PIDX_W    = $clog2(MAX_PG),
    localparam int EPP_LG    = $clog2(EPP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clean,
    input  logic              pg_we,
    input  logic [WIDX_W-1:0] pg_widx,
    input  logic [PPN_W-1:0]  pg_wppn,
    input  logic              init,
    input  logic [CNT_W-1:0]  init_pages,
    input  logic              init_allow,
    input  logic              step,
    input  logic              flush,
    input  logic [31:0]       peer,
    output logic [ADDR_W-1:0] addr_q,
    output logic              hit_q,
    output logic [31:0]       pub_q,
    output logic [5:0]        lg_q,
    output logic              live_q
);
    import dring_pkg::*;

    logic [31:0]       ptr_q, mask_q, masked, size, new_mask;
    logic [5:0]        new_lg;
    logic              init_ok, ok, wr_ok;
    logic [PPN_W-1:0]  cur_ppn;
    logic [ADDR_W-1:0] cur_addr;
    logic [EPP_LG-1:0] in_pg;

    // Setup acceptance and derived ring geometry.
    always_comb begin
        init_ok  = init && init_allow && (init_pages != '0) && (32'(init_pages) <= MAX_PG);
        size     = 32'(init_pages) * EPP;
        new_lg   = bit_len(size - 32'd1);
        new_mask = (32'd1 << new_lg) - 32'd1;
        wr_ok    = pg_we && (32'(pg_widx) < MAX_PG);
    end

    // Acceptance of a step, per ring variant.
    always_comb begin
        unique case (MODE)
            M_CONSUME: ok = live_q && (peer != ptr_q);
            M_PRODUCE: ok = live_q;
            default:   ok = live_q && ((ptr_q - peer) < (mask_q + 32'd1));
        endcase
    end

    // Slot address: page from masked index, offset from remainder.
    assign masked = ptr_q & mask_q;
    assign in_pg  = masked[EPP_LG-1:0];

    dring_pgtab #(.DEPTH(MAX_PG), .PPN_W(PPN_W)) u_pgtab (
        .clk   (clk),
        .rst_n (rst_n),
        .clean (clean),
        .we    (wr_ok),
        .widx  (pg_widx[PIDX_W-1:0]),
        .wppn  (pg_wppn),
        .ridx  (PIDX_W'(masked >> EPP_LG)),
        .rppn  (cur_ppn)
    );

    assign cur_addr = {cur_ppn, {PAGE_SHIFT{1'b0}}} + ADDR_W'(in_pg) * ADDR_W'(DESC_B);

    // Ring state: setup, step response, pointer advance and publication.
    always_ff @(posedge clk) begin
        if (!rst_n || clean) begin
            ptr_q  <= '0;
            pub_q  <= '0;
            mask_q <= '0;
            lg_q   <= '0;
            live_q <= 1'b0;
            hit_q  <= 1'b0;
            addr_q <= '0;
        end else if (init_ok) begin
            ptr_q  <= '0;
            pub_q  <= '0;
            mask_q <= new_mask;
            lg_q   <= new_lg;
            live_q <= 1'b1;
            hit_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            hit_q <= step && ok;
            if (step) addr_q <= ok ? cur_addr : '0;
            if (step && ok) ptr_q <= ptr_q + 32'd1;
            if (MODE == M_ROOM) begin
                if (step && ok) pub_q <= ptr_q + 32'd1;
            end else if (flush) begin
                pub_q <= ptr_q;
            end
        end
    end

    // R1: a live mask is always of the form 2^n - 1.
    a_r1_mask_shape: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (((mask_q + 32'd1) & mask_q) == 32'd0));

    // R1: setup leaves pointer and published index at zero, ring live.
    a_r1_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (init_ok && !clean) |=> (ptr_q == 32'd0 && pub_q == 32'd0 && live_q));

    // R3: an accepted step advances the free-running pointer by one.
    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ok && !init_ok && !clean) |=> (ptr_q == $past(ptr_q) + 32'd1));

    // R4: a refused step reports no hit and address zero.
    a_r4_refused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ok && !init_ok && !clean) |=> (!hit_q && addr_q == '0));

    // R5: batch-published indices hold unless flushed.
    a_r5_pub_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE != M_ROOM && !flush && !init_ok && !clean) |=> $stable(pub_q));

    // R8: an immediately published index holds when nothing is accepted.
    a_r8_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == M_ROOM && !(step && ok) && !init_ok && !clean) |=> $stable(pub_q));

    // R12: hit is a single-cycle pulse tied to a step.
    a_r12_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> !hit_q);

endmodule

// File: rtl/dring_index_mgr.sv
// Module: top of the descriptor ring index manager; one request ring
// (consumed), one completion ring and one message ring (produced).
// Assumes MSG_MAX_PAGES <= MAX_PAGES, both powers of two >= 2.
module dring_index_mgr #(
    parameter int ADDR_W        = 40,
    parameter int PAGE_SHIFT    = 12,
    parameter int MAX_PAGES     = 4,
    parameter int MSG_MAX_PAGES = 2,
    parameter int REQ_EPP       = 32,
    parameter int REQ_DESC_B    = 128,
    parameter int CMP_EPP       = 128,
    parameter int CMP_DESC_B    = 32,
    parameter int MSG_EPP       = 32,
    parameter int MSG_DESC_B    = 128,
    localparam int PG_IW        = $clog2(MAX_PAGES),
    localparam int PG_CW        = $clog2(MAX_PAGES + 1),
    localparam int PPN_W        = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clean,
    input  logic [1:0]        cfg_ring,
    input  logic              cfg_ppn_we,
    input  logic [PG_IW-1:0]  cfg_page,
    input  logic [PPN_W-1:0]  cfg_ppn,
    input  logic              cfg_init,
    input  logic [PG_CW-1:0]  cfg_pages,
    input  logic              req_pop,
    input  logic [31:0]       sw_req_prod,
    input  logic              req_flush,
    output logic [ADDR_W-1:0] req_addr,
    output logic              req_hit,
    input  logic              cmp_push,
    input  logic              cmp_flush,
    output logic [ADDR_W-1:0] cmp_addr,
    output logic              cmp_hit,
    input  logic              msg_post,
    input  logic [31:0]       sw_msg_cons,
    output logic [ADDR_W-1:0] msg_addr,
    output logic              msg_hit,
    output logic [31:0]       req_cons_pub,
    output logic [31:0]       cmp_prod_pub,
    output logic [31:0]       msg_prod_pub,
    output logic [5:0]        req_log2,
    output logic [5:0]        cmp_log2,
    output logic [5:0]        msg_log2,
    output logic [2:0]        ring_live
);
    import dring_pkg::*;

    logic [2:0] sel;

    // Decode of the configuration ring selector (3 selects nothing).
    always_comb begin
        sel = 3'b000;
        if (cfg_ring != 2'd3) sel[cfg_ring] = 1'b1;
    end

    dring_ring #(.MODE(M_CONSUME), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                 .MAX_PG(MAX_PAGES), .EPP(REQ_EPP), .DESC_B(REQ_DESC_B),
                 .WIDX_W(PG_IW), .CNT_W(PG_CW)) u_req (
        .clk(clk), .rst_n(rst_n), .clean(clean),
        .pg_we(cfg_ppn_we && sel[0]), .pg_widx(cfg_page), .pg_wppn(cfg_ppn),
        .init(cfg_init && sel[0]), .init_pages(cfg_pages), .init_allow(1'b1),
        .step(req_pop), .flush(req_flush), .peer(sw_req_prod),
        .addr_q(req_addr), .hit_q(req_hit), .pub_q(req_cons_pub),
        .lg_q(req_log2), .live_q(ring_live[0])
    );

    dring_ring #(.MODE(M_PRODUCE), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                 .MAX_PG(MAX_PAGES), .EPP(CMP_EPP), .DESC_B(CMP_DESC_B),
                 .WIDX_W(PG_IW), .CNT_W(PG_CW)) u_cmp (
        .clk(clk), .rst_n(rst_n), .clean(clean),
        .pg_we(cfg_ppn_we && sel[1]), .pg_widx(cfg_page), .pg_wppn(cfg_ppn),
        .init(cfg_init && sel[1]), .init_pages(cfg_pages), .init_allow(1'b1),
        .step(cmp_push), .flush(cmp_flush), .peer(32'd0),
        .addr_q(cmp_addr), .hit_q(cmp_hit), .pub_q(cmp_prod_pub),
        .lg_q(cmp_log2), .live_q(ring_live[1])
    );

    dring_ring #(.MODE(M_ROOM), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT),
                 .MAX_PG(MSG_MAX_PAGES), .EPP(MSG_EPP), .DESC_B(MSG_DESC_B),
                 .WIDX_W(PG_IW), .CNT_W(PG_CW)) u_msg (
        .clk(clk), .rst_n(rst_n), .clean(clean),
        .pg_we(cfg_ppn_we && sel[2]), .pg_widx(cfg_page), .pg_wppn(cfg_ppn),
        .init(cfg_init && sel[2]), .init_pages(cfg_pages), .init_allow(ring_live[0]),
        .step(msg_post), .flush(1'b0), .peer(sw_msg_cons),
        .addr_q(msg_addr), .hit_q(msg_hit), .pub_q(msg_prod_pub),
        .lg_q(msg_log2), .live_q(ring_live[2])
    );

endmodule

// File: tb/dring_index_mgr_tb.sv
module dring_index_mgr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 40;

    logic clk = 1'b0, rst_n = 1'b0, clean = 1'b0;
    logic [1:0] cfg_ring = 2'd0;
    logic cfg_ppn_we = 1'b0, cfg_init = 1'b0;
    logic [1:0] cfg_page = '0;
    logic [27:0] cfg_ppn = '0;
    logic [2:0] cfg_pages = '0;
    logic req_pop = 1'b0, req_flush = 1'b0, cmp_push = 1'b0, cmp_flush = 1'b0, msg_post = 1'b0;
    logic [31:0] sw_req_prod = '0, sw_msg_cons = '0;
    logic [AW-1:0] req_addr, cmp_addr, msg_addr;
    logic req_hit, cmp_hit, msg_hit;
    logic [31:0] req_cons_pub, cmp_prod_pub, msg_prod_pub;
    logic [5:0] req_log2, cmp_log2, msg_log2;
    logic [2:0] ring_live;

    int n_chk = 0, n_err = 0;
    int unsigned seed_v;
    bit done = 1'b0;

    // Reference model state
    int unsigned m_epp[3] = '{4, 8, 2};
    int unsigned m_desc[3] = '{128, 32, 128};
    int unsigned m_maxpg[3] = '{4, 4, 2};
    longint unsigned m_ppn[3][4];
    int unsigned m_ptr[3], m_pub[3], m_mask[3], m_lg[3];
    bit m_live[3];

    always #(CLK_PERIOD/2) clk = ~clk;

    dring_index_mgr #(.ADDR_W(AW), .PAGE_SHIFT(12), .MAX_PAGES(4), .MSG_MAX_PAGES(2),
        .REQ_EPP(4), .REQ_DESC_B(128), .CMP_EPP(8), .CMP_DESC_B(32),
        .MSG_EPP(2), .MSG_DESC_B(128)) u_dut (
        .clk(clk), .rst_n(rst_n), .clean(clean), .cfg_ring(cfg_ring),
        .cfg_ppn_we(cfg_ppn_we), .cfg_page(cfg_page), .cfg_ppn(cfg_ppn),
        .cfg_init(cfg_init), .cfg_pages(cfg_pages),
        .req_pop(req_pop), .sw_req_prod(sw_req_prod), .req_flush(req_flush),
        .req_addr(req_addr), .req_hit(req_hit),
        .cmp_push(cmp_push), .cmp_flush(cmp_flush), .cmp_addr(cmp_addr), .cmp_hit(cmp_hit),
        .msg_post(msg_post), .sw_msg_cons(sw_msg_cons), .msg_addr(msg_addr), .msg_hit(msg_hit),
        .req_cons_pub(req_cons_pub), .cmp_prod_pub(cmp_prod_pub), .msg_prod_pub(msg_prod_pub),
        .req_log2(req_log2), .cmp_log2(cmp_log2), .msg_log2(msg_log2), .ring_live(ring_live)
    );

    function automatic int unsigned blen(int unsigned v);
        int unsigned n = 0;
        while (v != 0) begin n++; v = v >> 1; end
        return n;
    endfunction

    function automatic longint unsigned exp_addr(int r);
        int unsigned m = m_ptr[r] & m_mask[r];
        int unsigned pg = m / m_epp[r];
        int unsigned off = m % m_epp[r];
        return (m_ppn[r][pg] << 12) + longint'(off) * m_desc[r];
    endfunction

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic chk_pubs(string rq);
        chk(rq, "req_cons_pub", 64'(req_cons_pub), 64'(m_pub[0]));
        chk(rq, "cmp_prod_pub", 64'(cmp_prod_pub), 64'(m_pub[1]));
        chk(rq, "msg_prod_pub", 64'(msg_prod_pub), 64'(m_pub[2]));
    endtask

    task automatic chk_cfg(string rq);
        chk(rq, "ring_live", 64'(ring_live), 64'({m_live[2], m_live[1], m_live[0]}));
        chk(rq, "req_log2", 64'(req_log2), 64'(m_lg[0]));
        chk(rq, "cmp_log2", 64'(cmp_log2), 64'(m_lg[1]));
        chk(rq, "msg_log2", 64'(msg_log2), 64'(m_lg[2]));
        chk_pubs(rq);
    endtask

    task automatic op_ppn(int r, int idx, int unsigned v);
        @(negedge clk);
        cfg_ring = 2'(r); cfg_page = 2'(idx); cfg_ppn = 28'(v); cfg_ppn_we = 1'b1;
        @(negedge clk);
        cfg_ppn_we = 1'b0;
        if (r < 3 && idx < int'(m_maxpg[r])) m_ppn[r][idx] = longint'(v & 32'h0FFF_FFFF);
    endtask

    task automatic op_init(string rq, int r, int pages);
        bit ok;
        @(negedge clk);
        cfg_ring = 2'(r); cfg_pages = 3'(pages); cfg_init = 1'b1;
        @(negedge clk);
        cfg_init = 1'b0;
        ok = (r < 3) && pages >= 1 && pages <= int'(m_maxpg[r]) && (r != 2 || m_live[0]);
        if (ok) begin
            m_lg[r] = blen(pages * m_epp[r] - 1);
            m_mask[r] = (32'd1 << m_lg[r]) - 1;
            m_ptr[r] = 0; m_pub[r] = 0; m_live[r] = 1'b1;
        end
        chk_cfg(rq);
    endtask

    task automatic op_pop(string rq, int unsigned prod);
        bit hit = m_live[0] && (prod != m_ptr[0]);
        longint unsigned ea = hit ? exp_addr(0) : 0;
        @(negedge clk);
        sw_req_prod = prod; req_pop = 1'b1;
        @(negedge clk);
        req_pop = 1'b0;
        if (hit) m_ptr[0]++;
        chk(rq, "req_hit", 64'(req_hit), 64'(hit));
        chk(rq, "req_addr", 64'(req_addr), ea);
        chk("R5", "req_cons_pub after pop", 64'(req_cons_pub), 64'(m_pub[0]));
    endtask

    task automatic op_push(string rq);
        bit hit = m_live[1];
        longint unsigned ea = hit ? exp_addr(1) : 0;
        @(negedge clk);
        cmp_push = 1'b1;
        @(negedge clk);
        cmp_push = 1'b0;
        if (hit) m_ptr[1]++;
        chk(rq, "cmp_hit", 64'(cmp_hit), 64'(hit));
        chk(rq, "cmp_addr", 64'(cmp_addr), ea);
        chk("R6", "cmp_prod_pub after push", 64'(cmp_prod_pub), 64'(m_pub[1]));
    endtask

    task automatic op_post(string rq, int unsigned cons);
        int unsigned diff = m_ptr[2] - cons;
        bit hit = m_live[2] && (diff < m_mask[2] + 1);
        longint unsigned ea = hit ? exp_addr(2) : 0;
        @(negedge clk);
        sw_msg_cons = cons; msg_post = 1'b1;
        @(negedge clk);
        msg_post = 1'b0;
        if (hit) begin m_ptr[2]++; m_pub[2] = m_ptr[2]; end
        chk(rq, "msg_hit", 64'(msg_hit), 64'(hit));
        chk(rq, "msg_addr", 64'(msg_addr), ea);
        chk(rq, "msg_prod_pub", 64'(msg_prod_pub), 64'(m_pub[2]));
    endtask

    task automatic op_flush(string rq, int r);
        @(negedge clk);
        if (r == 0) req_flush = 1'b1; else cmp_flush = 1'b1;
        @(negedge clk);
        req_flush = 1'b0; cmp_flush = 1'b0;
        m_pub[r] = m_ptr[r];
        chk_pubs(rq);
    endtask

    task automatic model_clear();
        for (int r = 0; r < 3; r++) begin
            m_ptr[r] = 0; m_pub[r] = 0; m_mask[r] = 0; m_lg[r] = 0; m_live[r] = 1'b0;
            for (int p = 0; p < 4; p++) m_ppn[r][p] = 0;
        end
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        seed_v = $urandom(32'h5eed_0042);
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk_cfg("R11");
        chk("R11", "req_hit", 64'(req_hit), 64'd0);
        chk("R11", "msg_addr", 64'(msg_addr), 64'd0);

        // R10: pops/pushes/posts before setup are refused
        op_pop("R10", 5);
        op_push("R10");
        op_post("R10", 0);

        // R9: message setup before request ring is live
        op_ppn(2, 0, 32'h77);
        op_init("R9", 2, 2);

        // R2: bad page counts
        op_init("R2", 0, 0);
        op_init("R2", 0, 5);
        op_init("R2", 3, 2);

        // R1: request ring, 3 pages -> 12 entries, log2 4, mask 15
        op_ppn(0, 0, 32'h100); op_ppn(0, 1, 32'h2A5); op_ppn(0, 2, 32'h333);
        op_init("R1", 0, 3);
        for (int p = 0; p < 4; p++) op_ppn(1, p, 32'h4000 + p * 17);
        op_init("R1", 1, 4);
        op_ppn(2, 0, 32'h800); op_ppn(2, 1, 32'h801);
        op_ppn(2, 3, 32'hBAD);   // R2: beyond message table, ignored
        op_init("R1", 2, 2);

        // R3/R4: three pops then empty
        for (int i = 0; i < 3; i++) op_pop("R3", 3);
        op_pop("R4", 3);
        op_flush("R5", 0);
        // R3: walk past ring size into unloaded page 3 and wrap the mask
        for (int i = 0; i < 20; i++) op_pop("R3", 23);
        op_pop("R4", 23);
        op_flush("R5", 0);

        // R12: hit is a one-cycle pulse
        op_pop("R12", 40);
        @(negedge clk);
        chk("R12", "req_hit after idle", 64'(req_hit), 64'd0);

        // R6: completions wrap with no full check
        for (int i = 0; i < 40; i++) op_push("R6");
        op_flush("R6", 1);

        // R7/R8: message room
        for (int i = 0; i < 4; i++) op_post("R7", 0);
        op_post("R8", 0);
        op_post("R7", 2);
        op_post("R7", 2);
        op_post("R8", 2);
        // R8: consumer ahead of producer -> wrapped difference is huge -> drop
        op_post("R8", m_ptr[2] + 1);
        // R7: wrapped subtraction that still fits
        op_post("R7", m_ptr[2] - 1);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 6);
            case (k)
                0, 1: op_pop("R3", m_ptr[0] + $urandom_range(0, 2));
                2:    op_push("R6");
                3:    op_post("R7", m_pub[2] - $urandom_range(0, 5));
                4:    op_flush("R5", 0);
                5:    op_flush("R6", 1);
                default: op_ppn($urandom_range(0, 2), $urandom_range(0, 3), $urandom);
            endcase
        end

        // R11: clean clears everything; unreloaded page gives base 0
        @(negedge clk); clean = 1'b1;
        @(negedge clk); clean = 1'b0;
        model_clear();
        chk_cfg("R11");
        op_init("R11", 0, 1);
        op_pop("R11", 4);
        op_pop("R11", 4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule